// File: doc/BRIEF.md
# Flash Command Write State Machine

This block is the command front end of a byte-wide NOR-style flash model. Every bus write lands on it. When no operation is open, the byte is read as a command. The command either switches the read mode that a separate read path uses, clears or adjusts the status register, or opens a two-cycle operation. The write that follows an opened operation supplies its data or its confirm byte. The block then issues a single-cycle strobe to the storage array, or it records why the operation was refused.

The storage array sits outside the block. A program strobe carries an address and a byte, and the array ANDs that byte into the stored value, so a program can only clear bits. An erase strobe carries one mask bit per 64 KB block, and every masked block is set to all ones. The block keeps one lock bit per block. An erase is refused on a locked block. The write-protect input decides whether lock bits may change and whether a full-chip erase may pass over locked blocks.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After synchronous reset, `rd_mode` is array (0), `status` is 0x80, only lock bit 0 is set, and neither strobe is active.
- R2: When no operation is open, 0xFF sets `rd_mode` to array (0), 0x90 to identifier (1), 0x98 to query (2) and 0x70 to status (3).
- R3: When no operation is open, 0x50 sets `status` to 0x00.
- R4: 0x40 or 0x10 opens a program. The next write raises `prog_en` for exactly one cycle with that write's address and data. After the strobe, the stored byte is the old value AND the data, and status bit 7 (ready) is set.
- R5: 0x20 followed by 0xD0 on an unlocked block raises `erase_en` for one cycle. The mask is one-hot at index address>>16, and that block then reads 0xFF.
- R6: A confirmed block erase on a locked block ORs 0x22 into `status` (bit 5 erase error, bit 1 protect). No strobe is issued and the data is left unchanged.
- R7: If the second write of an operation is not an accepted byte, `status` gets bits 5, 4 and 7 set, no strobe is issued, and the next write is decoded as a command.
- R8: 0x30 followed by 0xD0 erases every block when `wp_hi` is 1. When `wp_hi` is 0, it erases only unlocked blocks and, if any lock bit is set, ORs 0x22 into `status`.
- R9: 0x60 followed by 0xD0 clears every lock bit when `wp_hi` is 1. Otherwise it ORs 0x22 into `status` and leaves the lock bits as they were.
- R10: 0x60 followed by 0x01 sets the lock bit of block address>>16 when `wp_hi` is 1. Otherwise it ORs 0x12 into `status` (bit 4 program error, bit 1 protect).
- R11: When no operation is open, 0xB0 sets status bit 7, clears bits 6 and 2, and sets `rd_mode` to status (3).
- R12: When no operation is open, a byte with no assigned meaning changes neither `rd_mode`, `status`, the lock bits nor the strobes.
- R13: Opening any two-cycle operation (0x40, 0x10, 0x20, 0x30, 0x60) clears status bit 7 and sets `rd_mode` to status (3) until the second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one byte per cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Command, data or confirm byte |
| wp_hi | input | 1 | Write-protect level; 1 permits lock changes and erase of locked blocks by chip erase |
| rd_mode | output | 2 | Read mode: 0 array, 1 identifier, 2 query, 3 status |
| status | output | 8 | Status register |
| lock_bits | output | NBLK | One lock bit per block |
| prog_en | output | 1 | Single-cycle program strobe to the array |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Byte to AND into the array |
| erase_en | output | 1 | Single-cycle erase strobe |
| erase_mask | output | NBLK | Blocks to set to all ones |

## Verification
The hardest situation to reach is a full-chip erase with write-protect low. It only means something when lock bits have already been changed, and lock bits can only be changed while write-protect is high. The stimulus therefore follows a fixed order. It first writes data into several blocks, raises write-protect, and sets a second lock bit. It then lowers write-protect and issues the chip erase. The checks confirm that the locked blocks keep their data, that the unlocked blocks read erased, and that the protect flags appear. Afterwards the lock-clear command is tried both with write-protect low and with it high.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_QUERY  = 2'd2,
        RM_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_PROG,
        WS_BERASE,
        WS_CERASE,
        WS_LOCK
    } wr_state_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_MODE,
        OP_CLR_STAT,
        OP_PROG,
        OP_BERASE,
        OP_CERASE,
        OP_LOCK,
        OP_SUSPEND
    } op_e;

    typedef struct packed {
        op_e      op;
        rd_mode_e mode;
    } dec_t;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLRSTAT = 8'h50;
    localparam logic [7:0] CMD_PROG_A  = 8'h40;
    localparam logic [7:0] CMD_PROG_B  = 8'h10;
    localparam logic [7:0] CMD_BERASE  = 8'h20;
    localparam logic [7:0] CMD_CERASE  = 8'h30;
    localparam logic [7:0] CMD_LOCK    = 8'h60;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CNF_GO      = 8'hD0;
    localparam logic [7:0] CNF_SETLOCK = 8'h01;

    localparam int SB_READY  = 7;
    localparam int SB_SUSP_E = 6;
    localparam int SB_ERERR  = 5;
    localparam int SB_PGERR  = 4;
    localparam int SB_SUSP_P = 2;
    localparam int SB_PROT   = 1;

    localparam logic [7:0] ST_RESET = 8'h80;

    function automatic logic [7:0] st_set(input logic [7:0] s, input int b);
        logic [7:0] r;
        r = s;
        r[b] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] st_bad_seq(input logic [7:0] s);
        return st_set(st_set(s, SB_ERERR), SB_PGERR);
    endfunction

    function automatic logic [7:0] st_erase_prot(input logic [7:0] s);
        return st_set(st_set(s, SB_ERERR), SB_PROT);
    endfunction

    function automatic logic [7:0] st_lock_prot(input logic [7:0] s);
        return st_set(st_set(s, SB_PGERR), SB_PROT);
    endfunction

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] cmd,
    output dec_t       dec
);
    always_comb begin
        dec.op   = OP_NONE;
        dec.mode = RM_ARRAY;
        case (cmd)
            CMD_ARRAY:   begin dec.op = OP_MODE; dec.mode = RM_ARRAY;  end
            CMD_IDENT:   begin dec.op = OP_MODE; dec.mode = RM_IDENT;  end
            CMD_QUERY:   begin dec.op = OP_MODE; dec.mode = RM_QUERY;  end
            CMD_STATUS:  begin dec.op = OP_MODE; dec.mode = RM_STATUS; end
            CMD_CLRSTAT: dec.op = OP_CLR_STAT;
            CMD_PROG_A,
            CMD_PROG_B:  dec.op = OP_PROG;
            CMD_BERASE:  dec.op = OP_BERASE;
            CMD_CERASE:  dec.op = OP_CERASE;
            CMD_LOCK:    dec.op = OP_LOCK;
            CMD_SUSPEND: dec.op = OP_SUSPEND;
            default:     dec.op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/fcmd_lock_bank.sv
module fcmd_lock_bank #(
    parameter int NBLK = 16,
    localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    output logic [NBLK-1:0]  lock_q
);
    for (genvar g = 0; g < NBLK; g++) begin : g_bit
        localparam logic RST_VAL = (g == 0);
        always_ff @(posedge clk) begin
            if (rst)
                lock_q[g] <= RST_VAL;
            else if (clr_en)
                lock_q[g] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(g))
                lock_q[g] <= 1'b1;
        end
    end

    // R9
    clr_all_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> lock_q == '0);

    // R10
    set_one_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en) |=> lock_q[$past(set_idx)]);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BLK_SHIFT = 16,
    localparam int NBLK     = 1 << (ADDR_W - BLK_SHIFT),
    localparam int IDX_W    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wp_hi,
    output logic [1:0]        rd_mode,
    output logic [7:0]        status,
    output logic [NBLK-1:0]   lock_bits,
    output logic              prog_en,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_en,
    output logic [NBLK-1:0]   erase_mask
);
    dec_t             dec;
    wr_state_e        state_q, state_d;
    rd_mode_e         mode_q, mode_d;
    logic [7:0]       stat_q, stat_d;
    logic             prog_d, erase_d;
    logic [NBLK-1:0]  mask_d;
    logic             lk_set, lk_clr;
    logic [IDX_W-1:0] blk;
    logic             opens_two;

    assign blk = IDX_W'(wr_addr >> BLK_SHIFT);

    fcmd_decode u_dec (
        .cmd (wr_data),
        .dec (dec)
    );

    fcmd_lock_bank #(.NBLK(NBLK)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .set_en  (lk_set),
        .set_idx (blk),
        .clr_en  (lk_clr),
        .lock_q  (lock_bits)
    );

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        stat_d  = stat_q;
        prog_d  = 1'b0;
        erase_d = 1'b0;
        mask_d  = '0;
        lk_set  = 1'b0;
        lk_clr  = 1'b0;
        if (wr_en) begin
            case (state_q)
                WS_IDLE: begin
                    case (dec.op)
                        OP_MODE:     mode_d = dec.mode;
                        OP_CLR_STAT: stat_d = '0;
                        OP_PROG:     state_d = WS_PROG;
                        OP_BERASE:   state_d = WS_BERASE;
                        OP_CERASE:   state_d = WS_CERASE;
                        OP_LOCK:     state_d = WS_LOCK;
                        OP_SUSPEND: begin
                            stat_d[SB_READY]  = 1'b1;
                            stat_d[SB_SUSP_E] = 1'b0;
                            stat_d[SB_SUSP_P] = 1'b0;
                            mode_d = RM_STATUS;
                        end
                        default: ;
                    endcase
                    if (state_d != WS_IDLE) begin
                        stat_d[SB_READY] = 1'b0;
                        mode_d = RM_STATUS;
                    end
                end
                WS_PROG: begin
                    prog_d = 1'b1;
                end
                WS_BERASE: begin
                    if (wr_data != CNF_GO)
                        stat_d = st_bad_seq(stat_d);
                    else if (lock_bits[blk])
                        stat_d = st_erase_prot(stat_d);
                    else begin
                        erase_d = 1'b1;
                        mask_d  = NBLK'(1) << blk;
                    end
                end
                WS_CERASE: begin
                    if (wr_data != CNF_GO)
                        stat_d = st_bad_seq(stat_d);
                    else begin
                        mask_d  = wp_hi ? '1 : ~lock_bits;
                        erase_d = |mask_d;
                        if (!wp_hi && |lock_bits)
                            stat_d = st_erase_prot(stat_d);
                    end
                end
                WS_LOCK: begin
                    if (wr_data == CNF_SETLOCK) begin
                        if (wp_hi) lk_set = 1'b1;
                        else       stat_d = st_lock_prot(stat_d);
                    end else if (wr_data == CNF_GO) begin
                        if (wp_hi) lk_clr = 1'b1;
                        else       stat_d = st_erase_prot(stat_d);
                    end else
                        stat_d = st_bad_seq(stat_d);
                end
                default: state_d = WS_IDLE;
            endcase
            if (state_q != WS_IDLE) begin
                stat_d[SB_READY] = 1'b1;
                state_d = WS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WS_IDLE;
            mode_q     <= RM_ARRAY;
            stat_q     <= ST_RESET;
            prog_en    <= 1'b0;
            prog_addr  <= '0;
            prog_data  <= '0;
            erase_en   <= 1'b0;
            erase_mask <= '0;
        end else begin
            state_q    <= state_d;
            mode_q     <= mode_d;
            stat_q     <= stat_d;
            prog_en    <= prog_d;
            erase_en   <= erase_d;
            erase_mask <= mask_d;
            if (prog_d) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
        end
    end

    assign rd_mode = mode_q;
    assign status  = stat_q;

    assign opens_two = wr_en && state_q == WS_IDLE &&
        (dec.op inside {OP_PROG, OP_BERASE, OP_CERASE, OP_LOCK});

    // R13
    open_busy_chk: assert property (@(posedge clk) disable iff (rst)
        opens_two |=> (!status[7] && rd_mode == 2'd3));

    // R4
    prog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        prog_en |=> !prog_en);

    // R6
    erase_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && state_q == WS_BERASE) |=>
            (!erase_en || ((erase_mask & $past(lock_bits)) == '0 && $countones(erase_mask) == 1)));

    // R7
    bad_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (state_q == WS_BERASE || state_q == WS_CERASE) && wr_data != 8'hD0) |=>
            (status[7] && status[5] && status[4] && !erase_en));
endmodule

// File: tb/flash_cmd_fsm_tb_top.sv
module flash_cmd_fsm_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int NB = 16;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          wp_hi = 1'b0;
    logic [1:0]    rd_mode;
    logic [7:0]    status;
    logic [NB-1:0] lock_bits;
    logic          prog_en;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_data;
    logic          erase_en;
    logic [NB-1:0] erase_mask;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    flash_cmd_fsm dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wp_hi(wp_hi), .rd_mode(rd_mode), .status(status), .lock_bits(lock_bits),
        .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_en(erase_en), .erase_mask(erase_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural array wrapper, unwritten bytes read as 0xFF
    logic [7:0] mem [int];

    always @(posedge clk) begin
        if (prog_en)
            mem[int'(prog_addr)] = (mem.exists(int'(prog_addr)) ? mem[int'(prog_addr)] : 8'hFF) & prog_data;
        if (erase_en) begin
            int kq[$];
            foreach (mem[k]) if (erase_mask[k >> 16]) kq.push_back(k);
            foreach (kq[i]) mem.delete(kq[i]);
        end
    end

    function automatic logic [7:0] rd(int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    // reference model: 0 idle, 1 prog, 2 block erase, 3 chip erase, 4 lock
    int            m_st;
    int            m_mode;
    logic [7:0]    m_stat;
    logic [NB-1:0] m_lock;
    logic          m_prog, m_erase;
    logic [AW-1:0] m_paddr;
    logic [7:0]    m_pdata;
    logic [NB-1:0] m_mask;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_mode = 0; m_stat = 8'h80; m_lock = 16'h0001;
            m_prog = 0; m_erase = 0; m_mask = '0; m_paddr = '0; m_pdata = '0;
        end else begin
            m_prog = 0; m_erase = 0; m_mask = '0;
            if (wr_en) begin
                int b;
                b = int'(wr_addr) >> 16;
                if (m_st == 0) begin
                    case (wr_data)
                        8'hFF: m_mode = 0;
                        8'h90: m_mode = 1;
                        8'h98: m_mode = 2;
                        8'h70: m_mode = 3;
                        8'h50: m_stat = 8'h00;
                        8'h40, 8'h10: m_st = 1;
                        8'h20: m_st = 2;
                        8'h30: m_st = 3;
                        8'h60: m_st = 4;
                        8'hB0: begin m_stat = (m_stat | 8'h80) & 8'hBB; m_mode = 3; end
                        default: ;
                    endcase
                    if (m_st != 0) begin m_stat = m_stat & 8'h7F; m_mode = 3; end
                end else begin
                    if (m_st == 1) begin
                        m_prog = 1; m_paddr = wr_addr; m_pdata = wr_data;
                    end else if (wr_data == 8'hD0 && m_st == 2) begin
                        if (m_lock[b]) m_stat = m_stat | 8'h22;
                        else begin m_erase = 1; m_mask[b] = 1'b1; end
                    end else if (wr_data == 8'hD0 && m_st == 3) begin
                        for (int i = 0; i < NB; i++) m_mask[i] = wp_hi || !m_lock[i];
                        m_erase = (m_mask != 0);
                        if (!wp_hi && m_lock != 0) m_stat = m_stat | 8'h22;
                    end else if (wr_data == 8'hD0 && m_st == 4) begin
                        if (wp_hi) m_lock = '0; else m_stat = m_stat | 8'h22;
                    end else if (wr_data == 8'h01 && m_st == 4) begin
                        if (wp_hi) m_lock[b] = 1'b1; else m_stat = m_stat | 8'h12;
                    end else
                        m_stat = m_stat | 8'h30;
                    m_stat = m_stat | 8'h80;
                    m_st = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(rd_mode == 2'(m_mode), "R2", "rd_mode", int'(rd_mode), m_mode);
            chk(status == m_stat, "R3", "status", int'(status), int'(m_stat));
            chk(lock_bits == m_lock, "R9", "lock_bits", int'(lock_bits), int'(m_lock));
            chk(prog_en == m_prog, "R4", "prog_en", int'(prog_en), int'(m_prog));
            if (m_prog) begin
                chk(prog_addr == m_paddr, "R4", "prog_addr", int'(prog_addr), int'(m_paddr));
                chk(prog_data == m_pdata, "R4", "prog_data", int'(prog_data), int'(m_pdata));
            end
            chk(erase_en == m_erase, "R5", "erase_en", int'(erase_en), int'(m_erase));
            if (m_erase)
                chk(erase_mask == m_mask, "R8", "erase_mask", int'(erase_mask), int'(m_mask));
        end
    end

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rd_mode == 2'd0, "R1", "reset rd_mode", int'(rd_mode), 0);
        chk(status == 8'h80, "R1", "reset status", int'(status), 8'h80);
        chk(lock_bits == 16'h0001, "R1", "reset lock", int'(lock_bits), 1);
        chk(!prog_en && !erase_en, "R1", "reset strobes", int'({prog_en, erase_en}), 0);

        // R2 mode commands
        wr(0, 8'h90); chk(rd_mode == 2'd1, "R2", "ident mode", int'(rd_mode), 1);
        wr(0, 8'h98); chk(rd_mode == 2'd2, "R2", "query mode", int'(rd_mode), 2);
        wr(0, 8'h70); chk(rd_mode == 2'd3, "R2", "status mode", int'(rd_mode), 3);
        wr(0, 8'hFF); chk(rd_mode == 2'd0, "R2", "array mode", int'(rd_mode), 0);

        // R13 then R4 program
        wr(0, 8'h40);
        chk(!status[7] && rd_mode == 2'd3, "R13", "busy after open", int'({status[7], rd_mode}), 3);
        wr(32'h12345, 8'hA5); idle(1);
        chk(rd(32'h12345) == 8'hA5, "R4", "first program", int'(rd(32'h12345)), 8'hA5);
        chk(status[7], "R4", "ready after program", int'(status[7]), 1);
        wr(0, 8'h10); wr(32'h12345, 8'h0F); idle(1);
        chk(rd(32'h12345) == 8'h05, "R4", "program ANDs", int'(rd(32'h12345)), 8'h05);

        // R5 erase unlocked block 1
        wr(0, 8'h20); wr(32'h10000, 8'hD0); idle(1);
        chk(rd(32'h12345) == 8'hFF, "R5", "block erased", int'(rd(32'h12345)), 8'hFF);

        // R6 erase locked block 0
        wr(0, 8'h40); wr(32'h00010, 8'h3C);
        wr(0, 8'h20); wr(32'h00000, 8'hD0); idle(1);
        chk(rd(32'h00010) == 8'h3C, "R6", "locked data kept", int'(rd(32'h00010)), 8'h3C);
        chk(status == 8'hA2, "R6", "locked erase status", int'(status), 8'hA2);

        // R3 clear status
        wr(0, 8'h50);
        chk(status == 8'h00, "R3", "status cleared", int'(status), 0);

        // R7 improper sequence
        wr(0, 8'h20); wr(32'h30000, 8'h55);
        chk(status == 8'hB0, "R7", "bad confirm status", int'(status), 8'hB0);
        wr(0, 8'h90);
        chk(rd_mode == 2'd1, "R7", "back to idle", int'(rd_mode), 1);

        // R10 lock set
        wr(0, 8'h50);
        wp_hi = 1'b0; wr(0, 8'h60); wr(32'h20000, 8'h01);
        chk(status == 8'h92 && lock_bits == 16'h0001, "R10", "set refused", int'(status), 8'h92);
        wp_hi = 1'b1; wr(0, 8'h60); wr(32'h20000, 8'h01);
        chk(lock_bits == 16'h0005, "R10", "set block 2", int'(lock_bits), 5);

        // R8 chip erase with write-protect low
        wr(0, 8'h40); wr(32'h20004, 8'h11);
        wr(0, 8'h40); wr(32'h30004, 8'h22);
        wr(0, 8'h50);
        wp_hi = 1'b0; wr(0, 8'h30); wr(0, 8'hD0); idle(1);
        chk(rd(32'h20004) == 8'h11 && rd(32'h00010) == 8'h3C, "R8", "locked kept", int'(rd(32'h20004)), 8'h11);
        chk(rd(32'h30004) == 8'hFF, "R8", "unlocked erased", int'(rd(32'h30004)), 8'hFF);
        chk(status == 8'hA2, "R8", "protect flags", int'(status), 8'hA2);

        // R9 lock clear
        wr(0, 8'h50);
        wr(0, 8'h60); wr(0, 8'hD0);
        chk(status == 8'hA2 && lock_bits == 16'h0005, "R9", "clear refused", int'(status), 8'hA2);
        wp_hi = 1'b1; wr(0, 8'h60); wr(0, 8'hD0);
        chk(lock_bits == 16'h0000, "R9", "locks cleared", int'(lock_bits), 0);

        // R8 chip erase with write-protect high
        wp_hi = 1'b0;
        wr(0, 8'h60); wr(0, 8'h00);
        wp_hi = 1'b1; wr(0, 8'h60); wr(0, 8'h01);
        wr(0, 8'h30); wr(0, 8'hD0); idle(1);
        chk(rd(32'h00010) == 8'hFF && rd(32'h20004) == 8'hFF, "R8", "all erased", int'(rd(32'h00010)), 8'hFF);

        // R11 suspend
        wr(0, 8'h50); wr(0, 8'hFF);
        wr(0, 8'hB0);
        chk(status == 8'h80 && rd_mode == 2'd3, "R11", "suspend", int'(status), 8'h80);

        // R12 unknown commands
        wr(0, 8'hFF); wr(0, 8'h50);
        wr(0, 8'h00); wr(0, 8'hD0); wr(0, 8'hAB); wr(0, 8'h01);
        chk(rd_mode == 2'd0 && status == 8'h00, "R12", "unknown ignored", int'(status), 0);
        wr(0, 8'h40); wr(32'h50000, 8'h7E); idle(1);
        chk(rd(32'h50000) == 8'h7E, "R12", "next command normal", int'(rd(32'h50000)), 8'h7E);

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule